// File: doc/BRIEF.md
# Pointer-Addressed Serial Bus Register Slave with Alert Response

This block is the bus-facing part of a small sensor register file on a two-wire serial bus. It takes SCL and SDA as oversampled inputs in the system clock domain, brings them into that domain, and finds start conditions, stop conditions and clock edges. It pulls SDA low through a single open-drain enable. Only one 7-bit device address gets an answer. Every write puts its first data byte into an address pointer. A second data byte, if present, goes out on a one-cycle write strobe to the register file, addressed by that pointer. A read returns one byte from the register the pointer selects. The block requests that byte by address before it shifts out the first bit.

The block also answers the shared alert response address while its alert request input is high. In reply it sends its own address with a 1 in the least significant bit, and it arbitrates bit by bit against other devices that answer at the same time. When the block completes that reply without losing arbitration, it pulses a serviced output. The alert logic beside it uses that pulse to decide whether the alert line can be released.

Top module: `smb_ptr_slave`

## Requirements
- R1: A start condition (SDA falling while SCL is high) begins address decoding from any state, including in the middle of a transaction (repeated start). A stop condition (SDA rising while SCL is high) releases SDA and returns the block to idle. After reset SDA is released and no strobe or pulse output is active.
- R2: The address byte is sent MSB first, with the 7-bit address in bits 7:1 and R/W in bit 0 (1 = read). The device address is 0x4C, so the byte is 0x98 for a write and 0x99 for a read. A matching address byte is acknowledged by holding SDA low during the ninth clock. Any other address is not acknowledged. The block then keeps SDA released and makes no register access until the next start condition.
- R3: The first data byte of a write is acknowledged and stored in the address pointer. No write strobe is produced for it.
- R4: The second data byte of a write is acknowledged. It produces exactly one one-cycle write strobe carrying the pointer value as the address and the byte as the data.
- R5: A third or later data byte in the same write is not acknowledged and produces no write strobe.
- R6: A read returns, MSB first, one byte from the register addressed by the current pointer. The pointer keeps its value across any number of reads until a later write changes it.
- R7: After the eighth bit of a read byte the block releases SDA, so the master can drive the acknowledge or not-acknowledge bit and then a stop.
- R8: The alert response address 0x0C with R/W = 1 (byte 0x19) is acknowledged only while the alert request input is high. With the request low, or with R/W = 0, the address is ignored as in R2.
- R9: The reply to the alert response address is the own address followed by a 1, i.e. the byte 0x99, sent MSB first.
- R10: While sending, the block samples SDA on each rising SCL edge. If it has released the line for a 1 but reads back a 0, it stops driving for the rest of the transaction and gives no serviced pulse. The device with the lowest address therefore wins.
- R11: A won alert reply produces exactly one one-cycle serviced pulse, at the rising SCL edge of the ninth clock of that byte.
- R12: The open-drain enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 = pull SDA low |
| alert_req_i | input | 1 | Alert pending; enables the alert response reply |
| reg_wr_en_o | output | 1 | One-cycle register write strobe |
| reg_wr_addr_o | output | 8 | Write address (pointer value) |
| reg_wr_data_o | output | 8 | Write data byte |
| reg_rd_req_o | output | 1 | One-cycle register read request |
| reg_rd_addr_o | output | 8 | Read address (pointer value) |
| reg_rd_data_i | input | 8 | Read data, valid the cycle after the request |
| ara_serviced_o | output | 1 | One-cycle pulse after a won alert reply |

## Verification
A corrupted pointer cannot be seen directly at the ports. It shows up at the next read, which returns the wrong register, or at the next second data byte, which strobes the wrong address. For that reason every pointer write is followed by one or more reads. A wrong phase or bit count shows up within one byte: an acknowledge in the wrong place, a missing acknowledge, or a shifted read value. A lost-arbitration state that is held too long, or dropped too early, shows at the ninth clock of the alert reply, either as a serviced pulse that should not be there or as a corrupted byte on the line.

// File: rtl/smb_slv_pkg.sv
package smb_slv_pkg;

    localparam int BYTE_W       = 8;
    localparam int CNT_W        = $clog2(BYTE_W + 1);
    localparam int MAX_WR_BYTES = 2;
    localparam int IDX_W        = $clog2(MAX_WR_BYTES + 1);

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_ADDR_ACK,
        PH_WR_RX,
        PH_WR_ACK,
        PH_TX,
        PH_TX_ACK,
        PH_IGNORE
    } phase_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_evt_t;

    typedef struct packed {
        phase_e              phase;
        logic [CNT_W-1:0]    bit_cnt;
        logic [BYTE_W-1:0]   shreg;
        logic [BYTE_W-1:0]   ptr;
        logic [IDX_W-1:0]    data_idx;
        logic                rnw;
        logic                is_ara;
        logic                oe;
        logic                wr_en;
        logic [BYTE_W-1:0]   wr_data;
        logic                rd_req;
        logic                rd_load;
        logic                ara_pulse;
    } fsm_regs_t;

endpackage

// File: rtl/smb_bus_cond.sv
module smb_bus_cond
    import smb_slv_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_pipe;
        logic [SYNC_STAGES-1:0] sda_pipe;
        logic                   scl_prev;
        logic                   sda_prev;
    } cond_regs_t;

    cond_regs_t cond_d, cond_q;
    logic       scl_now, sda_now;

    assign scl_now = cond_q.scl_pipe[SYNC_STAGES-1];
    assign sda_now = cond_q.sda_pipe[SYNC_STAGES-1];

    always_comb begin
        cond_d          = cond_q;
        cond_d.scl_pipe = {cond_q.scl_pipe[SYNC_STAGES-2:0], scl_i};
        cond_d.sda_pipe = {cond_q.sda_pipe[SYNC_STAGES-2:0], sda_i};
        cond_d.scl_prev = scl_now;
        cond_d.sda_prev = sda_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cond_q <= '1;
        end else begin
            cond_q <= cond_d;
        end
    end

    // Events from the settled stage and its one-cycle-old copy
    always_comb begin
        evt_o.scl_rise = scl_now & ~cond_q.scl_prev;
        evt_o.scl_fall = ~scl_now & cond_q.scl_prev;
        evt_o.start    = scl_now & cond_q.scl_prev & cond_q.sda_prev & ~sda_now;
        evt_o.stop     = scl_now & cond_q.scl_prev & ~cond_q.sda_prev & sda_now;
        evt_o.sda      = sda_now;
    end

endmodule

// File: rtl/smb_slave_fsm.sv
module smb_slave_fsm
    import smb_slv_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h4C,
    parameter logic [6:0] ARA_ADDR = 7'h0C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_evt_t          evt_i,
    input  logic              alert_req_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic              sda_oe_o,
    output logic              wr_en_o,
    output logic [BYTE_W-1:0] wr_addr_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              rd_req_o,
    output logic [BYTE_W-1:0] rd_addr_o,
    output logic              ara_serviced_o
);

    localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(BYTE_W);
    localparam logic [BYTE_W-1:0] ARA_REPLY = {DEV_ADDR, 1'b1};

    fsm_regs_t fsm_d, fsm_q;
    logic [6:0] rx_addr;
    logic       rx_rnw;
    logic [BYTE_W-1:0] tx_next;

    assign rx_addr = fsm_q.shreg[BYTE_W-1:1];
    assign rx_rnw  = fsm_q.shreg[0];
    assign tx_next = {fsm_q.shreg[BYTE_W-2:0], 1'b1};

    always_comb begin
        fsm_d           = fsm_q;
        fsm_d.wr_en     = 1'b0;
        fsm_d.rd_req    = 1'b0;
        fsm_d.ara_pulse = 1'b0;
        fsm_d.rd_load   = fsm_q.rd_req;

        if (fsm_q.rd_load) begin
            fsm_d.shreg = rd_data_i;
        end

        if (evt_i.start) begin
            fsm_d.phase    = PH_ADDR;
            fsm_d.bit_cnt  = '0;
            fsm_d.data_idx = '0;
            fsm_d.is_ara   = 1'b0;
            fsm_d.oe       = 1'b0;
        end else if (evt_i.stop) begin
            fsm_d.phase = PH_IDLE;
            fsm_d.oe    = 1'b0;
        end else begin
            unique case (fsm_q.phase)
                PH_ADDR: begin
                    if (evt_i.scl_rise) begin
                        fsm_d.shreg   = {fsm_q.shreg[BYTE_W-2:0], evt_i.sda};
                        fsm_d.bit_cnt = fsm_q.bit_cnt + 1'b1;
                    end else if (evt_i.scl_fall && fsm_q.bit_cnt == LAST_BIT) begin
                        fsm_d.rnw = rx_rnw;
                        if (rx_addr == DEV_ADDR) begin
                            fsm_d.phase  = PH_ADDR_ACK;
                            fsm_d.oe     = 1'b1;
                            fsm_d.rd_req = rx_rnw;
                        end else if (rx_addr == ARA_ADDR && rx_rnw && alert_req_i) begin
                            fsm_d.phase  = PH_ADDR_ACK;
                            fsm_d.oe     = 1'b1;
                            fsm_d.is_ara = 1'b1;
                            fsm_d.shreg  = ARA_REPLY;
                        end else begin
                            fsm_d.phase = PH_IGNORE;
                            fsm_d.oe    = 1'b0;
                        end
                    end
                end

                PH_ADDR_ACK: begin
                    if (evt_i.scl_fall) begin
                        fsm_d.bit_cnt = '0;
                        if (fsm_q.rnw) begin
                            fsm_d.phase = PH_TX;
                            fsm_d.oe    = ~fsm_q.shreg[BYTE_W-1];
                        end else begin
                            fsm_d.phase = PH_WR_RX;
                            fsm_d.oe    = 1'b0;
                        end
                    end
                end

                PH_WR_RX: begin
                    if (evt_i.scl_rise) begin
                        fsm_d.shreg   = {fsm_q.shreg[BYTE_W-2:0], evt_i.sda};
                        fsm_d.bit_cnt = fsm_q.bit_cnt + 1'b1;
                    end else if (evt_i.scl_fall && fsm_q.bit_cnt == LAST_BIT) begin
                        if (fsm_q.data_idx == '0) begin
                            fsm_d.ptr      = fsm_q.shreg;
                            fsm_d.phase    = PH_WR_ACK;
                            fsm_d.oe       = 1'b1;
                            fsm_d.data_idx = fsm_q.data_idx + 1'b1;
                        end else if (fsm_q.data_idx < IDX_W'(MAX_WR_BYTES)) begin
                            fsm_d.wr_en    = 1'b1;
                            fsm_d.wr_data  = fsm_q.shreg;
                            fsm_d.phase    = PH_WR_ACK;
                            fsm_d.oe       = 1'b1;
                            fsm_d.data_idx = fsm_q.data_idx + 1'b1;
                        end else begin
                            fsm_d.phase = PH_IGNORE;
                            fsm_d.oe    = 1'b0;
                        end
                    end
                end

                PH_WR_ACK: begin
                    if (evt_i.scl_fall) begin
                        fsm_d.phase   = PH_WR_RX;
                        fsm_d.bit_cnt = '0;
                        fsm_d.oe      = 1'b0;
                    end
                end

                PH_TX: begin
                    if (evt_i.scl_rise) begin
                        fsm_d.bit_cnt = fsm_q.bit_cnt + 1'b1;
                        // Released for a 1 but line reads 0: arbitration lost
                        if (fsm_q.shreg[BYTE_W-1] && !evt_i.sda) begin
                            fsm_d.phase = PH_IGNORE;
                            fsm_d.oe    = 1'b0;
                        end
                    end else if (evt_i.scl_fall) begin
                        if (fsm_q.bit_cnt == LAST_BIT) begin
                            fsm_d.phase = PH_TX_ACK;
                            fsm_d.oe    = 1'b0;
                        end else begin
                            fsm_d.shreg = tx_next;
                            fsm_d.oe    = ~tx_next[BYTE_W-1];
                        end
                    end
                end

                PH_TX_ACK: begin
                    if (evt_i.scl_rise) begin
                        fsm_d.ara_pulse = fsm_q.is_ara;
                        fsm_d.phase     = PH_IGNORE;
                    end
                end

                PH_IDLE, PH_IGNORE: begin
                    fsm_d.oe = 1'b0;
                end

                default: begin
                    fsm_d.phase = PH_IDLE;
                    fsm_d.oe    = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q       <= '0;
            fsm_q.phase <= PH_IDLE;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign sda_oe_o       = fsm_q.oe;
    assign wr_en_o        = fsm_q.wr_en;
    assign wr_addr_o      = fsm_q.ptr;
    assign wr_data_o      = fsm_q.wr_data;
    assign rd_req_o       = fsm_q.rd_req;
    assign rd_addr_o      = fsm_q.ptr;
    assign ara_serviced_o = fsm_q.ara_pulse;

endmodule

// File: rtl/smb_ptr_slave.sv
module smb_ptr_slave
    import smb_slv_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h4C,
    parameter logic [6:0] ARA_ADDR    = 7'h0C,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic              alert_req_i,
    output logic              reg_wr_en_o,
    output logic [BYTE_W-1:0] reg_wr_addr_o,
    output logic [BYTE_W-1:0] reg_wr_data_o,
    output logic              reg_rd_req_o,
    output logic [BYTE_W-1:0] reg_rd_addr_o,
    input  logic [BYTE_W-1:0] reg_rd_data_i,
    output logic              ara_serviced_o
);

    bus_evt_t evt;
    logic     start_evt;
    logic     stop_evt;

    assign start_evt = evt.start;
    assign stop_evt  = evt.stop;

    smb_bus_cond #(
        .SYNC_STAGES(SYNC_STAGES)
    ) cond_i (
        .clk  (clk),
        .rst_n(rst_n),
        .scl_i(scl_i),
        .sda_i(sda_i),
        .evt_o(evt)
    );

    smb_slave_fsm #(
        .DEV_ADDR(DEV_ADDR),
        .ARA_ADDR(ARA_ADDR)
    ) fsm_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .evt_i         (evt),
        .alert_req_i   (alert_req_i),
        .rd_data_i     (reg_rd_data_i),
        .sda_oe_o      (sda_oe_o),
        .wr_en_o       (reg_wr_en_o),
        .wr_addr_o     (reg_wr_addr_o),
        .wr_data_o     (reg_wr_data_o),
        .rd_req_o      (reg_rd_req_o),
        .rd_addr_o     (reg_rd_addr_o),
        .ara_serviced_o(ara_serviced_o)
    );

endmodule

// File: rtl/smb_ptr_slave_chk.sv
module smb_ptr_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_oe,
    input logic wr_en,
    input logic rd_req,
    input logic ara,
    input logic start_evt,
    input logic stop_evt
);

    AST_WR_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en) else $error("write strobe longer than one cycle"); // R4

    AST_RD_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req) else $error("read request longer than one cycle"); // R6

    AST_ARA_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ara |=> !ara) else $error("serviced pulse longer than one cycle"); // R11

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_oe) else $error("SDA held after stop"); // R1

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((sda_oe != $past(sda_oe)) && !$past(start_evt) && !$past(stop_evt)) |-> !scl_i)
        else $error("SDA enable changed with SCL high"); // R12

endmodule

bind smb_ptr_slave smb_ptr_slave_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_oe   (sda_oe_o),
    .wr_en    (reg_wr_en_o),
    .rd_req   (reg_rd_req_o),
    .ara      (ara_serviced_o),
    .start_evt(start_evt),
    .stop_evt (stop_evt)
);

// File: tb/smb_ptr_slave_tb_top.sv
module smb_ptr_slave_tb_top;

    localparam int Q = 5;
    localparam logic [1:0] K_WPTR = 2'd0;
    localparam logic [1:0] K_WREG = 2'd1;
    localparam logic [1:0] K_RD   = 2'd2;

    typedef struct packed {
        logic [1:0] kind;
        logic [7:0] b0;
        logic [7:0] b1;
        logic [7:0] exp;
    } vec_t;

    localparam vec_t VECS [0:8] = '{
        '{K_WREG, 8'h10, 8'h3C, 8'h00},
        '{K_RD,   8'h00, 8'h00, 8'h3C},
        '{K_WPTR, 8'h22, 8'h00, 8'h00},
        '{K_RD,   8'h00, 8'h00, 8'h87},
        '{K_RD,   8'h00, 8'h00, 8'h87},
        '{K_WREG, 8'h05, 8'hF0, 8'h00},
        '{K_RD,   8'h00, 8'h00, 8'hF0},
        '{K_WPTR, 8'h7F, 8'h00, 8'h00},
        '{K_RD,   8'h00, 8'h00, 8'hDA}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic comp_sda = 1'b1;
    logic alert_req = 1'b0;
    logic sda_bus;
    logic sda_oe, wr_en, rd_req, ara;
    logic [7:0] wr_addr, wr_data, rd_addr;
    logic [7:0] rd_data;
    logic [7:0] mem [256];
    int wr_cnt, ara_cnt, oe_viol;
    logic [7:0] last_wr_addr, last_wr_data;
    logic prev_oe;
    int n_chk = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    assign sda_bus = m_sda & comp_sda & ~sda_oe;

    smb_ptr_slave dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_i         (scl),
        .sda_i         (sda_bus),
        .sda_oe_o      (sda_oe),
        .alert_req_i   (alert_req),
        .reg_wr_en_o   (wr_en),
        .reg_wr_addr_o (wr_addr),
        .reg_wr_data_o (wr_data),
        .reg_rd_req_o  (rd_req),
        .reg_rd_addr_o (rd_addr),
        .reg_rd_data_i (rd_data),
        .ara_serviced_o(ara)
    );

    // Register file model with one-cycle read latency
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'hA5;
            rd_data <= '0;
            wr_cnt <= 0; ara_cnt <= 0; oe_viol <= 0;
            last_wr_addr <= '0; last_wr_data <= '0;
            prev_oe <= 1'b0;
        end else begin
            if (rd_req) rd_data <= mem[rd_addr];
            if (wr_en) begin
                mem[wr_addr] <= wr_data;
                wr_cnt <= wr_cnt + 1;
                last_wr_addr <= wr_addr;
                last_wr_data <= wr_data;
            end
            if (ara) ara_cnt <= ara_cnt + 1;
            prev_oe <= sda_oe;
            if (prev_oe != sda_oe && scl) oe_viol <= oe_viol + 1;
        end
    end

    task automatic finish_test();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bit_io(input logic b, output logic s);
        m_sda = b; wait_q();
        scl = 1'b1; wait_q();
        s = sda_bus; wait_q();
        scl = 1'b0; wait_q();
    endtask

    task automatic start_cond();
        m_sda = 1'b1; wait_q();
        scl = 1'b1; wait_q();
        m_sda = 1'b0; wait_q();
        scl = 1'b0; wait_q();
    endtask

    task automatic stop_cond();
        m_sda = 1'b0; wait_q();
        scl = 1'b1; wait_q();
        m_sda = 1'b1; wait_q(); wait_q();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_io(b[i], s);
        bit_io(1'b1, s);
        ack = !s;
    endtask

    task automatic recv_byte(input logic use_comp, input logic [7:0] comp, output logic [7:0] v);
        logic s;
        logic lost = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            comp_sda = (use_comp && !lost) ? comp[i] : 1'b1;
            bit_io(1'b1, s);
            v[i] = s;
            if (use_comp && comp[i] && !s) lost = 1'b1;
        end
        comp_sda = 1'b1;
        bit_io(1'b1, s);
    endtask

    task automatic do_read(input string req, input logic [7:0] exp);
        logic ack;
        logic [7:0] v;
        start_cond();
        send_byte(8'h99, ack);
        chk("R2 read address ack", 32'(ack), 32'd1);
        recv_byte(1'b0, 8'h00, v);
        chk("R7 SDA released after read byte", 32'(sda_oe), 32'd0);
        stop_cond();
        chk(req, 32'(v), 32'(exp));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R1 watchdog expired actual=running expected=done");
            finish_test();
        end
    end

    initial begin
        logic ack;
        logic [7:0] v;
        int wc0, ac0;

        repeat (4) @(negedge clk);
        chk("R1 reset oe", 32'(sda_oe), 32'd0);
        chk("R1 reset strobe", 32'(wr_en | rd_req | ara), 32'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // Vector table: pointer writes, register writes, reads
        foreach (VECS[k]) begin
            wc0 = wr_cnt;
            if (VECS[k].kind == K_RD) begin
                do_read("R6 read data from pointer", VECS[k].exp);
            end else begin
                start_cond();
                send_byte(8'h98, ack);
                chk("R2 write address ack", 32'(ack), 32'd1);
                send_byte(VECS[k].b0, ack);
                chk("R3 pointer byte ack", 32'(ack), 32'd1);
                if (VECS[k].kind == K_WREG) begin
                    send_byte(VECS[k].b1, ack);
                    chk("R4 data byte ack", 32'(ack), 32'd1);
                end
                stop_cond();
                if (VECS[k].kind == K_WREG) begin
                    chk("R4 one strobe", 32'(wr_cnt - wc0), 32'd1);
                    chk("R4 strobe address", 32'(last_wr_addr), 32'(VECS[k].b0));
                    chk("R4 strobe data", 32'(last_wr_data), 32'(VECS[k].b1));
                end else begin
                    chk("R3 no strobe for pointer", 32'(wr_cnt - wc0), 32'd0);
                end
            end
        end

        // Wrong address: ignored, pointer kept (R2)
        wc0 = wr_cnt;
        start_cond();
        send_byte(8'h9A, ack);
        chk("R2 foreign address nack", 32'(ack), 32'd0);
        send_byte(8'h44, ack);
        chk("R2 foreign data nack", 32'(ack), 32'd0);
        send_byte(8'h55, ack);
        stop_cond();
        chk("R2 foreign no strobe", 32'(wr_cnt - wc0), 32'd0);
        do_read("R2 pointer unchanged by foreign write", 8'hDA);

        // Third data byte refused (R5)
        wc0 = wr_cnt;
        start_cond();
        send_byte(8'h98, ack);
        send_byte(8'h40, ack);
        send_byte(8'h11, ack);
        chk("R4 second byte ack", 32'(ack), 32'd1);
        send_byte(8'h22, ack);
        chk("R5 third byte nack", 32'(ack), 32'd0);
        stop_cond();
        chk("R5 only one strobe", 32'(wr_cnt - wc0), 32'd1);
        chk("R5 last data", 32'(last_wr_data), 32'h11);

        // Repeated start: pointer write then read (R1)
        start_cond();
        send_byte(8'h98, ack);
        send_byte(8'h30, ack);
        start_cond();
        send_byte(8'h99, ack);
        chk("R1 repeated start ack", 32'(ack), 32'd1);
        recv_byte(1'b0, 8'h00, v);
        stop_cond();
        chk("R1 repeated start read", 32'(v), 32'(8'h30 ^ 8'hA5));

        // Alert response, request low (R8)
        ac0 = ara_cnt;
        start_cond();
        send_byte(8'h19, ack);
        chk("R8 ARA nack without request", 32'(ack), 32'd0);
        recv_byte(1'b0, 8'h00, v);
        stop_cond();
        chk("R8 bus idle high", 32'(v), 32'hFF);
        chk("R8 no pulse", 32'(ara_cnt - ac0), 32'd0);

        // Alert response, request high, write direction (R8)
        alert_req = 1'b1;
        start_cond();
        send_byte(8'h18, ack);
        chk("R8 ARA write nack", 32'(ack), 32'd0);
        stop_cond();

        // Alert response won alone (R9, R11)
        ac0 = ara_cnt;
        start_cond();
        send_byte(8'h19, ack);
        chk("R8 ARA ack with request", 32'(ack), 32'd1);
        recv_byte(1'b0, 8'h00, v);
        chk("R11 one pulse", 32'(ara_cnt - ac0), 32'd1);
        stop_cond();
        chk("R9 reply byte", 32'(v), 32'h99);

        // Arbitration lost to lower address 0x18 (R10)
        ac0 = ara_cnt;
        start_cond();
        send_byte(8'h19, ack);
        recv_byte(1'b1, 8'h31, v);
        chk("R10 released after loss", 32'(sda_oe), 32'd0);
        stop_cond();
        chk("R10 winner byte on line", 32'(v), 32'h31);
        chk("R10 no pulse after loss", 32'(ara_cnt - ac0), 32'd0);

        // Arbitration won against higher address 0x5A (R10)
        ac0 = ara_cnt;
        start_cond();
        send_byte(8'h19, ack);
        recv_byte(1'b1, 8'hB5, v);
        stop_cond();
        chk("R10 own byte wins", 32'(v), 32'h99);
        chk("R10 pulse after win", 32'(ara_cnt - ac0), 32'd1);
        alert_req = 1'b0;

        chk("R12 enable changes only with SCL low", 32'(oe_viol), 32'd0);

        done = 1'b1;
        finish_test();
    end

endmodule